// File: doc/BRIEF.md
# Code-Group Lane Synchronization Monitor

This block watches the stream of 10-bit code groups arriving on one serial lane and decides whether the lane is synchronized. A word aligner and decoder upstream mark each group, and this block sees only their flags. A strobe says a group is present. One flag marks a comma group (K28.5). Another marks a group that is invalid or has a disparity error. A group with neither flag set is a good data group.

To acquire sync, the block needs a set number of comma groups, each on an even code-group position. The first comma seen while hunting defines the even position, and the position then alternates with every group. Once in sync, invalid groups add to an error count. Every run of consecutive good groups of a set length takes one away from that count. Sync is lost when the count reaches its limit. The sync status is a registered output for each lane, used by later deskew and lane-bonding logic.

Top module: `lane_sync`

## Requirements
- R1: While reset is active, and in the cycle after it is released, `sync_o` is 0 and the monitor is hunting.
- R2: `sync_o` rises at the clock edge that takes in the fourth counted comma (NUM_COMMA = 4). A comma counts when it comes after the anchoring comma at an even position, where positions alternate 0/1 with each accepted group. Good non-comma groups may sit between the commas.
- R3: An invalid group during acquisition sends the monitor back to hunting and clears the comma count. The next comma anchors a new attempt.
- R4: A comma at an odd position during acquisition also sends the monitor back to hunting.
- R5: While in sync, each invalid group raises the error count by one. The fourth error that is not cancelled (NUM_ERR = 4) drops `sync_o` at that clock edge.
- R6: While in sync with a nonzero error count, each NUM_GOOD = 4 consecutive good groups (commas included) lower the error count by one. Good groups never drop `sync_o`.
- R7: An invalid group received in sync clears the run of good groups collected so far.
- R8: Cycles with `grp_en` low change neither `sync_o` nor any count, whatever the flags show.
- R9: When `grp_bad` and `grp_comma` are both high, the group is treated as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_en | input | 1 | A code group is present this cycle |
| grp_comma | input | 1 | The group is a K28.5 comma |
| grp_bad | input | 1 | The group is invalid or has a disparity error |
| sync_o | output | 1 | Lane synchronized (registered) |

## Verification
The assertions assume the flags matter only when `grp_en` is high. They also assume `grp_bad` overrides `grp_comma`, so a rise in sync can be traced to a clean comma and a fall to an invalid group. The random stimulus sends commas mostly on the positions the bench's own parity tracker calls even. This lets acquisition finish often, while a few misplaced commas, idle cycles with random flags and a small rate of invalid groups also reach the restart and loss paths. Directed runs then set the exact error and good-run counts at the limits of the hysteresis.

// File: rtl/lane_sync.sv
module lane_sync #(
  parameter int NUM_COMMA = 4,
  parameter int NUM_ERR   = 4,
  parameter int NUM_GOOD  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grp_en,
  input  logic grp_comma,
  input  logic grp_bad,
  output logic sync_o
);
  localparam int AW = $clog2(NUM_COMMA + 1);
  localparam int EW = $clog2(NUM_ERR + 1);
  localparam int GW = $clog2(NUM_GOOD + 1);

  typedef enum logic [1:0] {HUNT, ACQ, LOCK} st_t;

  st_t           st;
  logic [AW-1:0] acq_cnt;
  logic [EW-1:0] err_cnt;
  logic [GW-1:0] good_cnt;
  logic          odd;

  wire clean_comma = grp_comma & ~grp_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= HUNT;
      acq_cnt  <= '0;
      err_cnt  <= '0;
      good_cnt <= '0;
      odd      <= 1'b0;
    end else if (grp_en) begin
      odd <= ~odd;
      case (st)
        HUNT: begin
          if (clean_comma) begin
            st      <= ACQ;
            acq_cnt <= AW'(1);
            odd     <= 1'b1;
          end
        end
        ACQ: begin
          if (grp_bad || (grp_comma && odd)) begin
            st      <= HUNT;
            acq_cnt <= '0;
          end else if (grp_comma) begin
            if (acq_cnt == AW'(NUM_COMMA - 1)) begin
              st       <= LOCK;
              acq_cnt  <= '0;
              err_cnt  <= '0;
              good_cnt <= '0;
            end else begin
              acq_cnt <= acq_cnt + AW'(1);
            end
          end
        end
        default: begin
          if (grp_bad) begin
            good_cnt <= '0;
            if (err_cnt == EW'(NUM_ERR - 1)) begin
              st      <= HUNT;
              err_cnt <= '0;
            end else begin
              err_cnt <= err_cnt + EW'(1);
            end
          end else if (err_cnt != '0) begin
            if (good_cnt == GW'(NUM_GOOD - 1)) begin
              good_cnt <= '0;
              err_cnt  <= err_cnt - EW'(1);
            end else begin
              good_cnt <= good_cnt + GW'(1);
            end
          end
        end
      endcase
    end
  end

  assign sync_o = (st == LOCK);
endmodule

module lane_sync_chk #(
  parameter int NUM_ERR  = 4,
  parameter int NUM_GOOD = 4,
  parameter int EW = 3,
  parameter int GW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grp_en,
  input logic          grp_comma,
  input logic          grp_bad,
  input logic          sync_o,
  input logic [EW-1:0] err_cnt,
  input logic [GW-1:0] good_cnt
);
  // R2
  rise_on_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(grp_en && grp_comma && !grp_bad));
  // R5
  fall_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_o) |-> $past(grp_en && grp_bad));
  // R5
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt < EW'(NUM_ERR));
  // R6
  good_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && grp_en && !grp_bad) |=> sync_o);
  // R7
  bad_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && grp_en && grp_bad) |=> (good_cnt == '0));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_en |=> ($stable(sync_o) && $stable(err_cnt) && $stable(good_cnt)));
  // R6
  good_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_cnt < GW'(NUM_GOOD));
endmodule

bind lane_sync lane_sync_chk #(.NUM_ERR(NUM_ERR), .NUM_GOOD(NUM_GOOD), .EW(EW), .GW(GW)) u_chk (.*);

// File: tb/sim_lane_sync.sv
module sim_lane_sync;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grp_en = 1'b0, grp_comma = 1'b0, grp_bad = 1'b0;
  logic sync_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_st = 0, m_acq = 0, m_err = 0, m_good = 0;
  bit m_odd = 0;

  always #4 clk = ~clk;

  lane_sync u0 (.clk(clk), .rst_n(rst_n), .grp_en(grp_en), .grp_comma(grp_comma),
                .grp_bad(grp_bad), .sync_o(sync_o));

  function automatic bit exp_sync();
    return m_st == 2;
  endfunction

  task automatic model(input bit e, input bit c, input bit b);
    if (!e) return;
    m_odd = !m_odd;
    if (m_st == 0) begin
      if (c && !b) begin m_st = 1; m_acq = 1; m_odd = 1; end
    end else if (m_st == 1) begin
      if (b) begin m_st = 0; m_acq = 0; end
      else if (c) begin
        if (!m_odd) begin m_st = 0; m_acq = 0; end
        else begin
          m_acq++;
          if (m_acq == 4) begin m_st = 2; m_acq = 0; m_err = 0; m_good = 0; end
        end
      end
    end else begin
      if (b) begin
        m_good = 0; m_err++;
        if (m_err == 4) begin m_st = 0; m_err = 0; end
      end else if (m_err > 0) begin
        m_good++;
        if (m_good == 4) begin m_good = 0; m_err--; end
      end
    end
  endtask

  task automatic chk(input string tag, input bit exp);
    n_chk++;
    if (sync_o !== exp) begin
      n_bad++;
      $display("FAIL %s: sync_o=%0b expected %0b", tag, sync_o, exp);
    end
  endtask

  task automatic step(input bit e, input bit c, input bit b, input string tag);
    @(negedge clk);
    grp_en = e; grp_comma = c; grp_bad = b;
    @(posedge clk);
    model(e, c, b);
    #2;
    chk(tag, exp_sync());
  endtask

  task automatic cm(input string t); step(1, 1, 0, t); endtask
  task automatic dt(input string t); step(1, 0, 0, t); endtask
  task automatic bd(input string t); step(1, 0, 1, t); endtask

  task automatic acquire(input string t);
    cm(t); dt(t); cm(t); dt(t); cm(t); dt(t); cm(t);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #3; chk("R1 in reset", 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1; chk("R1 after release", 1'b0);

    cm("R2"); dt("R2"); cm("R2"); dt("R2"); cm("R2"); dt("R2");
    chk("R2 three commas", 1'b0);
    cm("R2 fourth comma"); chk("R2 sync", 1'b1);

    bd("R6"); bd("R6"); bd("R6");
    dt("R6"); dt("R6"); cm("R6"); dt("R6");
    bd("R6 after recovery"); chk("R6 still synced", 1'b1);
    bd("R6 fourth net error"); chk("R5 loss", 1'b0);

    acquire("R2 reacquire"); chk("R2 relock", 1'b1);
    bd("R7"); bd("R7"); bd("R7"); dt("R7"); dt("R7"); dt("R7");
    bd("R7 run cleared"); chk("R7 loss", 1'b0);

    cm("R3"); dt("R3"); cm("R3"); bd("R3 restart");
    cm("R3"); dt("R3"); cm("R3"); dt("R3"); cm("R3");
    chk("R3 count cleared", 1'b0);
    dt("R3"); cm("R3"); chk("R3 relock", 1'b1);

    bd("R5"); bd("R5"); bd("R5"); bd("R5"); chk("R5 four errors", 1'b0);

    cm("R4"); cm("R4 odd comma");
    cm("R4"); dt("R4"); cm("R4"); dt("R4"); cm("R4");
    chk("R4 restart held", 1'b0);
    dt("R4"); cm("R4"); chk("R4 relock", 1'b1);

    step(1, 1, 1, "R9"); step(1, 1, 1, "R9"); step(1, 1, 1, "R9");
    step(1, 1, 1, "R9"); chk("R9 comma+bad is error", 1'b0);
    step(1, 1, 1, "R9 hunt"); chk("R9 no anchor", 1'b0);

    acquire("R8"); bd("R8"); bd("R8"); bd("R8");
    for (int i = 0; i < 6; i++) step(0, 1'($urandom), 1'($urandom), "R8 idle");
    chk("R8 held", 1'b1);
    bd("R8 count kept"); chk("R8 loss after idle", 1'b0);

    for (int i = 0; i < 4000; i++) begin
      int r;
      bit e, c, b;
      r = int'($urandom_range(99));
      e = (r < 88);
      b = ($urandom_range(99) < 6);
      c = m_odd ? ($urandom_range(99) < 4) : ($urandom_range(99) < 55);
      step(e, c, b, "R2/R3/R4/R5/R6/R7/R8/R9 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule